// File: doc/BRIEF.md
# Relocatable Peripheral Window Decoder

This block sorts every bus access into one of four outcomes. The access can go to a fixed 4 KB peripheral register page, to a dedicated CAN controller region, or to a general programmable peripheral region. If none of these apply, it gets a "none" result.

The two programmable regions sit inside a 16 KB window, and software places that window once after reset. The base register takes a single write. The write is a 4 KB page number whose two low bits are forced to zero, so the window is always 16 KB aligned. After that write the register is locked until the next reset. The top 4 KB of the window mirrors the fixed peripheral page: an access there selects the fixed target with the same 12-bit offset.

The window is switched off as a whole in two cases:

- it would reach past the highest allowed base;
- it overlaps ROM, RAM or the fixed page.

While it is off, addresses in its range fall through as "none", so the memory decoders keep them. The fixed page at the top of the address space is decoded in every state.

Accesses arrive on a valid/ready input and leave through one register stage on a valid/ready output. The input is ready when the output stage is empty or is being drained in the same cycle. A held result stays unchanged until the consumer takes it. The valid strobe must not drop before acceptance.

Top module: `reloc_win_decoder`

## Requirements
- R1: Addresses 0x3FFF000 to 0x3FFFFFF always select the fixed target (sel_fix) with sel_off equal to the address's low 12 bits, whether or not a window is active.
- R2: After reset and before any base write, base_locked and win_active are 0 and no address outside the fixed page selects any target.
- R3: Only the first base_we after reset is taken. base_locked is 1 from the next cycle on, and later writes change neither the window nor the decode.
- R4: Window offsets 0x0000 to 0x11FF of an active window select sel_can, with sel_off equal to the window offset.
- R5: Window offsets 0x1200 to 0x2FFF of an active window select sel_gen, with sel_off equal to the window offset minus 0x1200.
- R6: Window offsets 0x3000 to 0x3FFF of an active window select sel_fix, with sel_off equal to the window offset minus 0x3000. This is the same offset a direct access to the fixed page produces.
- R7: A base whose window would end above 0x1FFFFFF leaves win_active at 0, and the window range gives "none". A window ending exactly at 0x1FFFFFF is active.
- R8: A window that overlaps the ROM range (default 0x0000000 to 0x03FFFFF), the RAM range (default 0x1000000 to 0x10FFFFF) or the fixed page is inactive, and its range gives "none".
- R9: An access accepted in one cycle appears with sel_valid on the next cycle. At most one of sel_can, sel_gen and sel_fix is 1, and only while sel_valid is 1. A "none" result is sel_valid with all three selects at 0.
- R10: acc_ready equals (not sel_valid) or sel_ready. While sel_valid is 1 and sel_ready is 0, the selects and sel_off stay unchanged.
- R11: The two low bits of base_page are ignored: the window starts at the written page rounded down to a multiple of four pages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| base_we | input | 1 | Base register write strobe |
| base_page | input | ADDR_W-PAGE_W | Window base as a 4 KB page number |
| base_locked | output | 1 | Base register has taken its one write |
| win_active | output | 1 | Window is placed and legal |
| acc_valid | input | 1 | Access address valid |
| acc_ready | output | 1 | Access accepted when high with acc_valid |
| acc_addr | input | ADDR_W | Access byte address |
| sel_valid | output | 1 | Decode result valid |
| sel_ready | input | 1 | Consumer takes the result |
| sel_can | output | 1 | CAN controller region selected |
| sel_gen | output | 1 | General programmable region selected |
| sel_fix | output | 1 | Fixed peripheral page selected (direct or mirrored) |
| sel_off | output | PAGE_W+2 | Offset inside the selected region |

## Verification
Several window placements are tried, each after its own reset:

- **No base yet.** Tells the fixed page apart from the unplaced window.
- **Legal mid-range base with unaligned low bits.** Exercises the CAN, general and mirrored sub-regions, including both edges of each. A rewrite attempt follows to show the first value holds.
- **Base past the limit, and a base ending exactly on the limit.** Separates the illegal case from the last legal one.
- **Bases inside RAM and inside ROM.** Show that overlap kills the whole window while the fixed page keeps working.

The consumer's ready follows a stall pattern in part of the run, so held results and input back-pressure are compared against the model on every cycle.

// File: rtl/rwd_pkg.sv
package rwd_pkg;
  typedef enum logic [1:0] {
    RG_NONE = 2'd0,
    RG_CAN  = 2'd1,
    RG_GEN  = 2'd2,
    RG_FIX  = 2'd3
  } region_e;
endpackage

// File: rtl/rwd_base_reg.sv
// Write-once window base plus legality check of the placed window.
module rwd_base_reg #(
  parameter int              ADDR_W    = 26,
  parameter int              PAGE_W    = 12,
  parameter logic [ADDR_W-1:0] WIN_LIMIT = 26'h1FFFFFF,
  parameter logic [ADDR_W-1:0] ROM_LO    = 26'h0000000,
  parameter logic [ADDR_W-1:0] ROM_HI    = 26'h03FFFFF,
  parameter logic [ADDR_W-1:0] RAM_LO    = 26'h1000000,
  parameter logic [ADDR_W-1:0] RAM_HI    = 26'h10FFFFF
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     base_we,
  input  logic [ADDR_W-PAGE_W-1:0] base_page,
  output logic                     locked,
  output logic                     active,
  output logic [ADDR_W-1:0]        win_start
);
  localparam int PN_W   = ADDR_W - PAGE_W;
  localparam int OFF_W  = PAGE_W + 2;
  localparam int N_GUARD = 3;
  localparam logic [ADDR_W-1:0] FIX_BASE = {{PN_W{1'b1}}, {PAGE_W{1'b0}}};
  localparam logic [ADDR_W-1:0] WIN_SPAN = ADDR_W'((1 << OFF_W) - 1);
  localparam logic [ADDR_W-1:0] G_LO [N_GUARD] = '{ROM_LO, RAM_LO, FIX_BASE};
  localparam logic [ADDR_W-1:0] G_HI [N_GUARD] = '{ROM_HI, RAM_HI, {ADDR_W{1'b1}}};

  logic [PN_W-1:0]    page_q;
  logic [ADDR_W-1:0]  win_end;
  logic [N_GUARD-1:0] clash;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked <= 1'b0;
      page_q <= '0;
    end else if (base_we && !locked) begin
      locked <= 1'b1;
      page_q <= base_page & ~PN_W'(3);
    end
  end

  assign win_start = {page_q, {PAGE_W{1'b0}}};
  assign win_end   = win_start + WIN_SPAN;

  for (genvar g = 0; g < N_GUARD; g++) begin : g_guard
    assign clash[g] = (win_start <= G_HI[g]) && (win_end >= G_LO[g]);
  end

  assign active = locked && (win_end <= WIN_LIMIT) && (clash == '0);
endmodule

// File: rtl/rwd_region_map.sv
// Combinational address-to-target map with sub-region offsets.
module rwd_region_map
  import rwd_pkg::*;
#(
  parameter int ADDR_W  = 26,
  parameter int PAGE_W  = 12,
  parameter int CAN_END = 'h1200,
  parameter int GEN_END = 'h3000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] win_start,
  input  logic              win_active,
  output region_e           region,
  output logic [PAGE_W+1:0] offset
);
  localparam int OFF_W = PAGE_W + 2;
  localparam logic [ADDR_W-1:0] FIX_BASE = {{(ADDR_W-PAGE_W){1'b1}}, {PAGE_W{1'b0}}};
  localparam logic [OFF_W-1:0]  CAN_LIM  = OFF_W'(CAN_END);
  localparam logic [OFF_W-1:0]  GEN_LIM  = OFF_W'(GEN_END);

  logic [ADDR_W-1:0] rel;
  logic [OFF_W-1:0]  wofs;
  logic              in_fix, in_win;

  always_comb begin
    rel    = addr - win_start;
    wofs   = rel[OFF_W-1:0];
    in_fix = addr >= FIX_BASE;
    in_win = win_active && (addr >= win_start) && (rel[ADDR_W-1:OFF_W] == '0);
    region = RG_NONE;
    offset = '0;
    if (in_fix) begin
      region = RG_FIX;
      offset = {2'b00, addr[PAGE_W-1:0]};
    end else if (in_win) begin
      if (wofs < CAN_LIM) begin
        region = RG_CAN;
        offset = wofs;
      end else if (wofs < GEN_LIM) begin
        region = RG_GEN;
        offset = wofs - CAN_LIM;
      end else begin
        region = RG_FIX;
        offset = {2'b00, wofs[PAGE_W-1:0]};
      end
    end
  end
endmodule

// File: rtl/reloc_win_decoder.sv
module reloc_win_decoder
  import rwd_pkg::*;
#(
  parameter int                ADDR_W    = 26,
  parameter int                PAGE_W    = 12,
  parameter logic [ADDR_W-1:0] WIN_LIMIT = 26'h1FFFFFF,
  parameter logic [ADDR_W-1:0] ROM_LO    = 26'h0000000,
  parameter logic [ADDR_W-1:0] ROM_HI    = 26'h03FFFFF,
  parameter logic [ADDR_W-1:0] RAM_LO    = 26'h1000000,
  parameter logic [ADDR_W-1:0] RAM_HI    = 26'h10FFFFF,
  parameter int                CAN_END   = 'h1200,
  parameter int                GEN_END   = 'h3000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     base_we,
  input  logic [ADDR_W-PAGE_W-1:0] base_page,
  output logic                     base_locked,
  output logic                     win_active,
  input  logic                     acc_valid,
  output logic                     acc_ready,
  input  logic [ADDR_W-1:0]        acc_addr,
  output logic                     sel_valid,
  input  logic                     sel_ready,
  output logic                     sel_can,
  output logic                     sel_gen,
  output logic                     sel_fix,
  output logic [PAGE_W+1:0]        sel_off
);
  localparam int OFF_W = PAGE_W + 2;

  logic [ADDR_W-1:0] win_start;
  region_e           region_d, region_q;
  logic [OFF_W-1:0]  off_d, off_q;
  logic              valid_q;
  logic [3:1]        hot;

  rwd_base_reg #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WIN_LIMIT(WIN_LIMIT),
    .ROM_LO(ROM_LO), .ROM_HI(ROM_HI), .RAM_LO(RAM_LO), .RAM_HI(RAM_HI)
  ) u_base (
    .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_page(base_page),
    .locked(base_locked), .active(win_active), .win_start(win_start)
  );

  rwd_region_map #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .CAN_END(CAN_END), .GEN_END(GEN_END)
  ) u_map (
    .addr(acc_addr), .win_start(win_start), .win_active(win_active),
    .region(region_d), .offset(off_d)
  );

  assign acc_ready = !valid_q || sel_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      region_q <= RG_NONE;
      off_q    <= '0;
    end else if (acc_valid && acc_ready) begin
      valid_q  <= 1'b1;
      region_q <= region_d;
      off_q    <= off_d;
    end else if (sel_ready) begin
      valid_q  <= 1'b0;
    end
  end

  for (genvar i = 1; i < 4; i++) begin : g_hot
    assign hot[i] = valid_q && (region_q == region_e'(i));
  end

  assign sel_valid = valid_q;
  assign sel_can   = hot[1];
  assign sel_gen   = hot[2];
  assign sel_fix   = hot[3];
  assign sel_off   = off_q;
endmodule

// File: rtl/rwd_checker.sv
module rwd_checker #(
  parameter int PAGE_W  = 12,
  parameter int CAN_END = 'h1200,
  parameter int GEN_END = 'h3000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              base_we,
  input logic              base_locked,
  input logic              win_active,
  input logic              acc_valid,
  input logic              acc_ready,
  input logic              sel_valid,
  input logic              sel_ready,
  input logic              sel_can,
  input logic              sel_gen,
  input logic              sel_fix,
  input logic [PAGE_W+1:0] sel_off
);
  localparam int OFF_W = PAGE_W + 2;

  p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_can, sel_gen, sel_fix}));
  p_sel_needs_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_can || sel_gen || sel_fix) |-> sel_valid);
  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_ready) |=> sel_valid);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && !sel_ready) |=> (sel_valid && $stable({sel_can, sel_gen, sel_fix, sel_off})));
  p_lock_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    base_locked |=> base_locked);
  p_lock_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    base_we |=> base_locked);
  p_win_needs_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
    win_active |-> base_locked);
  p_region_needs_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_can || sel_gen) |-> base_locked);
  p_can_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sel_can |-> (sel_off < OFF_W'(CAN_END)));
  p_gen_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sel_gen |-> (sel_off < OFF_W'(GEN_END - CAN_END)));
  p_fix_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sel_fix |-> (sel_off[OFF_W-1:PAGE_W] == '0));
endmodule

bind reloc_win_decoder rwd_checker #(
  .PAGE_W(PAGE_W), .CAN_END(CAN_END), .GEN_END(GEN_END)
) u_chk (
  .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_locked(base_locked),
  .win_active(win_active), .acc_valid(acc_valid), .acc_ready(acc_ready),
  .sel_valid(sel_valid), .sel_ready(sel_ready), .sel_can(sel_can),
  .sel_gen(sel_gen), .sel_fix(sel_fix), .sel_off(sel_off)
);

// File: tb/reloc_win_decoder_tb.sv
module reloc_win_decoder_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_we = 1'b0;
  logic [13:0] base_page = '0;
  logic        base_locked, win_active;
  logic        acc_valid = 1'b0;
  logic        acc_ready;
  logic [25:0] acc_addr = '0;
  logic        sel_valid;
  logic        sel_ready = 1'b1;
  logic        sel_can, sel_gen, sel_fix;
  logic [13:0] sel_off;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit stall_mode = 0;

  // behavioural reference state
  bit m_lock;
  int m_base;
  bit m_val;
  int m_reg;   // 0 none, 1 can, 2 gen, 3 fixed
  int m_off;

  always #(CLK_P/2) clk = ~clk;

  reloc_win_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_page(base_page),
    .base_locked(base_locked), .win_active(win_active),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_addr(acc_addr),
    .sel_valid(sel_valid), .sel_ready(sel_ready), .sel_can(sel_can),
    .sel_gen(sel_gen), .sel_fix(sel_fix), .sel_off(sel_off)
  );

  function automatic bit m_active();
    int s = m_base;
    int e = m_base + 'h3FFF;
    if (!m_lock) return 0;
    if (e > 'h1FFFFFF) return 0;
    if (s <= 'h03FFFFF) return 0;
    if (s <= 'h10FFFFF && e >= 'h1000000) return 0;
    if (e >= 'h3FFF000) return 0;
    return 1;
  endfunction

  task automatic m_decode(input int a, output int rg, output int off);
    rg = 0; off = 0;
    if (a >= 'h3FFF000) begin
      rg = 3; off = a - 'h3FFF000;
    end else if (m_active() && a >= m_base && a < m_base + 'h4000) begin
      int o = a - m_base;
      if (o < 'h1200)      begin rg = 1; off = o; end
      else if (o < 'h3000) begin rg = 2; off = o - 'h1200; end
      else                 begin rg = 3; off = o - 'h3000; end
    end
  endtask

  task automatic compare(input string tag);
    bit bad = 0;
    checks++;
    if (sel_valid !== m_val || base_locked !== m_lock || win_active !== m_active()) bad = 1;
    if (m_val && (sel_can !== (m_reg == 1) || sel_gen !== (m_reg == 2) ||
                  sel_fix !== (m_reg == 3) || (m_reg != 0 && sel_off !== 14'(m_off)))) bad = 1;
    if (!m_val && (sel_can || sel_gen || sel_fix)) bad = 1;
    if (bad) begin
      errors++;
      $display("FAIL %s: actual v=%0b can=%0b gen=%0b fix=%0b off=%h lock=%0b act=%0b expected v=%0b reg=%0d off=%h lock=%0b act=%0b",
               tag, sel_valid, sel_can, sel_gen, sel_fix, sel_off, base_locked, win_active,
               m_val, m_reg, 14'(m_off), m_lock, m_active());
    end
  endtask

  task automatic cycle(input bit av, input int addr, input bit we, input int pg,
                       input string tag, output bit acc);
    bit rdy = stall_mode ? (cyc % 3 != 0) : 1'b1;
    bit rdy_exp = !m_val || rdy;
    int rg, off;
    acc_valid = av; acc_addr = 26'(addr); base_we = we; base_page = 14'(pg);
    sel_ready = rdy;
    #1;
    checks++;
    if (acc_ready !== rdy_exp) begin
      errors++;
      $display("FAIL R10 (%s): acc_ready actual %0b expected %0b", tag, acc_ready, rdy_exp);
    end
    acc = av && rdy_exp;
    if (acc) begin
      m_decode(addr, rg, off);
      m_val = 1; m_reg = rg; m_off = off;
    end else if (rdy) m_val = 0;
    if (we && !m_lock) begin
      m_lock = 1; m_base = (pg & ~3) << 12;
    end
    @(posedge clk);
    @(negedge clk);
    cyc++;
    acc_valid = 0; base_we = 0;
    compare(tag);
  endtask

  task automatic send(input int addr, input string tag);
    bit acc = 0;
    while (!acc) cycle(1, addr, 0, 0, tag, acc);
  endtask

  task automatic idle(input int n, input string tag);
    bit acc;
    for (int i = 0; i < n; i++) cycle(0, 0, 0, 0, tag, acc);
  endtask

  task automatic wr_base(input int pg, input string tag);
    bit acc;
    cycle(0, 0, 1, pg, tag, acc);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; acc_valid = 0; base_we = 0; sel_ready = 1;
    m_lock = 0; m_base = 0; m_val = 0; m_reg = 0; m_off = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    compare("R2 reset state");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog R9: actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // no base written yet
    do_reset();
    send('h0000100, "R2");
    send('h0800000, "R2");
    send('h3FFF004, "R1");
    send('h3FFFFFF, "R1");
    idle(2, "R2");

    // legal base with unaligned low page bits, then a stalling consumer
    do_reset();
    wr_base('h0803, "R11");
    idle(1, "R3");
    stall_mode = 1;
    send('h0800000, "R4");
    send('h08011FF, "R4");
    send('h0801200, "R5");
    send('h0802FFF, "R5");
    send('h0803000, "R6");
    send('h0803ABC, "R6");
    send('h3FFFABC, "R1");
    send('h0804000, "R9");
    send('h07FFFFF, "R9");
    idle(3, "R10");
    stall_mode = 0;
    wr_base('h0900, "R3");
    send('h0800010, "R3");
    send('h0900010, "R3");
    idle(2, "R3");

    // base beyond the limit
    do_reset();
    wr_base('h2000, "R7");
    send('h2000010, "R7");
    send('h3FFF010, "R1");
    idle(1, "R7");

    // base ending exactly on the limit
    do_reset();
    wr_base('h1FFC, "R7");
    send('h1FFC004, "R7");
    send('h1FFF000, "R6");
    idle(1, "R7");

    // base inside RAM
    do_reset();
    wr_base('h1004, "R8");
    send('h1004000, "R8");
    send('h3FFF123, "R1");
    idle(1, "R8");

    // base inside ROM
    do_reset();
    wr_base('h0010, "R8");
    send('h0010000, "R8");
    send('h0012000, "R8");
    idle(1, "R8");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule